// File: doc/BRIEF.md
# Store Queue with Load Forwarding Search

This block is a small in-order store queue that answers forwarding lookups from a two-stage load pipeline. Stores are allocated at the tail. Each store later receives its address lines and byte mask on one port and its 16 data bytes on another, and it retires from the head in program order. Each entry keeps a virtual line address, a physical line address, a 16-bit byte mask, 128 data bits, and separate flags that say whether the address and the data are known.

A load presents its virtual and physical line addresses, its byte mask and a vector that marks which queue entries are older than the load. That vector is computed upstream, so the lookup never compares pointers. The answer comes in two parts:

- **Fast result, same cycle.** A byte mask and a data-not-ready hint, both based on the virtual match.
- **Full result, one cycle later.** Taken from the physical match. Each byte comes from the youngest older store that covers it. The full result also carries two replay causes, each with the index of the store responsible, and a flag raised when the virtual and physical matches disagree. That flag asks the machine to flush.

Addresses are compared as 16-byte lines, so the ports carry only the address bits above the byte offset. Byte overlap is then decided by the masks. Age runs from the head entry, which is the oldest, toward the tail.

Top module: `sqf_top`

## Requirements
- R1: After reset the queue is empty (`sqEmpty`=1, `sqFull`=0, `allocIdx`=0). All stage-2 outputs are zero.
- R2: Allocation fills entries at the tail in index order, modulo 8. `allocIdx` shows the next entry. With 8 entries held, `sqFull` is 1 and a further allocation request is ignored: the queue stays full and not empty.
- R3: A retire request frees the head entry. On an empty queue it is ignored and `sqEmpty` stays 1.
- R4: An address/mask write takes two cycles to become visible. A query in the cycle right after the request cycle still sees that store's address as unknown. A query one cycle later sees the new address.
- R5: In the query cycle, bit b of `fastFwdMask` is 1 when the youngest in-scope, address-known store whose virtual line equals the query's and whose mask covers byte b (with query mask bit b set) has its data. If such a selected store lacks data, `fastDataNotReady` is 1.
- R6: One cycle after a query, `fwdMask` and `fwdData` give, for each requested byte b, the data byte b (bits 8b+7:8b) of the youngest in-scope, address-known store whose physical line matches and whose mask covers b. Bytes with no such store have a zero mask bit and zero data.
- R7: If the store selected for some byte has no data yet, that byte's `fwdMask` bit is 0 and `dataNotReady` is 1. `dataNotReadyIdx` is the youngest such store.
- R8: If any in-scope store's address is unknown, `addrNotReady` is 1 and `addrNotReadyIdx` is the oldest such store.
- R9: `vpMismatch` is 1 one cycle after a query in which, for some in-scope, address-known store with byte overlap, the virtual line match differs from the physical line match.
- R10: Only entries that are both marked in `qOlderMask` and currently allocated take part in a lookup. When `qValid` is 0 the fast outputs are zero, and the stage-2 outputs of the next cycle are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| allocReq | input | 1 | Allocate one store at the tail |
| retireReq | input | 1 | Free the head store |
| allocIdx | output | 3 | Entry the next allocation takes |
| sqFull | output | 1 | All entries in use |
| sqEmpty | output | 1 | No entry in use |
| staValid | input | 1 | Address/mask write request |
| staIdx | input | 3 | Entry for the address write |
| staVline | input | 16 | Virtual address bits above the 16-byte offset |
| staPline | input | 20 | Physical address bits above the 16-byte offset |
| staMask | input | 16 | Store byte mask |
| stdValid | input | 1 | Data write request, visible the next cycle |
| stdIdx | input | 3 | Entry for the data write |
| stdData | input | 128 | Store data, byte b at bits 8b+7:8b |
| qValid | input | 1 | Load lookup request |
| qVline | input | 16 | Load virtual line address |
| qPline | input | 20 | Load physical line address |
| qMask | input | 16 | Load byte mask |
| qOlderMask | input | 8 | Entries older than the load, bit per entry index |
| fastFwdMask | output | 16 | Same-cycle forwardable bytes (virtual match) |
| fastDataNotReady | output | 1 | Same-cycle data-not-ready hint |
| fwdMask | output | 16 | Stage-2 forwarded bytes |
| fwdData | output | 128 | Stage-2 forwarded data |
| dataNotReady | output | 1 | Replay: matching store without data |
| dataNotReadyIdx | output | 3 | Entry of that store |
| addrNotReady | output | 1 | Replay: older store with unknown address |
| addrNotReadyIdx | output | 3 | Entry of that store |
| vpMismatch | output | 1 | Virtual and physical matches disagree; flush |

## Verification
Directed cases separate the two-cycle address visibility from one-cycle data visibility. Stacked stores on one line, partly overlapping, show whether selection picks the youngest older store for each byte and not the oldest or any store. A younger store without data, sitting over an older store with data, shows whether the replay cause wins and names the correct index. An aliased virtual line and an older-vector that includes free entries or leaves out allocated ones check the flush flag and the scope rule. Random sequences then mix allocation, retirement with wrap-around, address and data writes, and lookups whose older-vectors are either age prefixes from the head or arbitrary. These are compared against a per-byte youngest-store model.

// File: rtl/sqf_pkg.sv
package sqf_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic allocEn;
    logic retireEn;
    logic staWrEn;
  } sqStrobe_t;
endpackage

// File: rtl/sqf_ctrl.sv
module sqf_ctrl
  import sqf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocReq,
  input  logic             retireReq,
  input  logic             staValid,
  input  logic [IDX_W-1:0] staIdx,
  output sqStrobe_t        strobe,
  output logic [IDX_W-1:0] allocIdx,
  output logic [IDX_W-1:0] headIdx,
  output logic [IDX_W-1:0] staWrIdx,
  output logic             sqFull,
  output logic             sqEmpty
);
  logic [IDX_W:0]   headPtr;
  logic [IDX_W:0]   tailPtr;
  logic             staPipeV;
  logic [IDX_W-1:0] staPipeIdx;

  assign sqEmpty = (headPtr == tailPtr);
  assign sqFull  = (headPtr[IDX_W-1:0] == tailPtr[IDX_W-1:0]) &&
                   (headPtr[IDX_W] != tailPtr[IDX_W]);

  assign strobe.allocEn  = allocReq & ~sqFull;
  assign strobe.retireEn = retireReq & ~sqEmpty;
  assign strobe.staWrEn  = staPipeV;

  assign allocIdx = tailPtr[IDX_W-1:0];
  assign headIdx  = headPtr[IDX_W-1:0];
  assign staWrIdx = staPipeIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr    <= '0;
      tailPtr    <= '0;
      staPipeV   <= 1'b0;
      staPipeIdx <= '0;
    end else begin
      if (strobe.allocEn)  tailPtr <= tailPtr + 1'b1;
      if (strobe.retireEn) headPtr <= headPtr + 1'b1;
      staPipeV   <= staValid;
      staPipeIdx <= staIdx;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    ((IDX_W+1)'(tailPtr - headPtr) <= (IDX_W+1)'(DEPTH))); // R2
  AST_FULL_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (sqFull && allocReq && !retireReq) |=> (sqFull && $stable(tailPtr))); // R2
  AST_EMPTY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (sqEmpty && retireReq && !allocReq) |=> (sqEmpty && $stable(headPtr))); // R3
endmodule

// File: rtl/sqf_dpath.sv
module sqf_dpath
  import sqf_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int BYTES   = 16,
  parameter int VLINE_W = 16,
  parameter int PLINE_W = 20,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int DATA_W = BYTES * BYTE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  sqStrobe_t          strobe,
  input  logic [IDX_W-1:0]   allocIdx,
  input  logic [IDX_W-1:0]   headIdx,
  input  logic [IDX_W-1:0]   staWrIdx,
  input  logic               staValid,
  input  logic [VLINE_W-1:0] staVline,
  input  logic [PLINE_W-1:0] staPline,
  input  logic [BYTES-1:0]   staMask,
  input  logic               stdValid,
  input  logic [IDX_W-1:0]   stdIdx,
  input  logic [DATA_W-1:0]  stdData,
  input  logic               qValid,
  input  logic [VLINE_W-1:0] qVline,
  input  logic [PLINE_W-1:0] qPline,
  input  logic [BYTES-1:0]   qMask,
  input  logic [DEPTH-1:0]   qOlderMask,
  output logic [BYTES-1:0]   fastFwdMask,
  output logic               fastDataNotReady,
  output logic [BYTES-1:0]   fwdMask,
  output logic [DATA_W-1:0]  fwdData,
  output logic               dataNotReady,
  output logic [IDX_W-1:0]   dataNotReadyIdx,
  output logic               addrNotReady,
  output logic [IDX_W-1:0]   addrNotReadyIdx,
  output logic               vpMismatch
);
  // address write payload stage (first of the two cycles)
  logic [VLINE_W-1:0] pipeVline;
  logic [PLINE_W-1:0] pipePline;
  logic [BYTES-1:0]   pipeMask;

  logic [DEPTH-1:0]   entValid;
  logic [DEPTH-1:0]   entAv;
  logic [DEPTH-1:0]   entDv;
  logic [VLINE_W-1:0] entVline [DEPTH];
  logic [PLINE_W-1:0] entPline [DEPTH];
  logic [BYTES-1:0]   entMask  [DEPTH];
  logic [DATA_W-1:0]  entData  [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeVline <= '0;
      pipePline <= '0;
      pipeMask  <= '0;
    end else if (staValid) begin
      pipeVline <= staVline;
      pipePline <= staPline;
      pipeMask  <= staMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
      entAv    <= '0;
      entDv    <= '0;
      for (int e = 0; e < DEPTH; e++) begin
        entVline[e] <= '0;
        entPline[e] <= '0;
        entMask[e]  <= '0;
        entData[e]  <= '0;
      end
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (strobe.allocEn && allocIdx == IDX_W'(e)) begin
          entValid[e] <= 1'b1;
          entAv[e]    <= 1'b0;
          entDv[e]    <= 1'b0;
        end else begin
          if (strobe.retireEn && headIdx == IDX_W'(e)) entValid[e] <= 1'b0;
          if (strobe.staWrEn && staWrIdx == IDX_W'(e)) begin
            entAv[e]    <= 1'b1;
            entVline[e] <= pipeVline;
            entPline[e] <= pipePline;
            entMask[e]  <= pipeMask;
          end
          if (stdValid && stdIdx == IDX_W'(e)) begin
            entDv[e]   <= 1'b1;
            entData[e] <= stdData;
          end
        end
      end
    end
  end

  // per-entry match terms
  logic [DEPTH-1:0] inScope;
  logic [DEPTH-1:0] overlap;
  logic [DEPTH-1:0] vHit;
  logic [DEPTH-1:0] pHit;
  logic [DEPTH-1:0] anrCand;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    assign inScope[e] = qOlderMask[e] & entValid[e];
    assign overlap[e] = |(entMask[e] & qMask);
    assign vHit[e]    = inScope[e] & entAv[e] & overlap[e] & (entVline[e] == qVline);
    assign pHit[e]    = inScope[e] & entAv[e] & overlap[e] & (entPline[e] == qPline);
    assign anrCand[e] = inScope[e] & ~entAv[e];
  end

  // per-byte youngest-older selection, walking age order from the head
  logic [BYTES-1:0]  fastMaskC;
  logic              fastDnrC;
  logic [BYTES-1:0]  fwdMaskC;
  logic [DATA_W-1:0] fwdDataC;
  logic [DEPTH-1:0]  ownerUnrdy;
  logic              dnrC;
  logic [IDX_W-1:0]  dnrIdxC;
  logic              anrC;
  logic [IDX_W-1:0]  anrIdxC;
  logic              mismC;

  always_comb begin
    fastMaskC  = '0;
    fastDnrC   = 1'b0;
    fwdMaskC   = '0;
    fwdDataC   = '0;
    ownerUnrdy = '0;
    for (int b = 0; b < BYTES; b++) begin
      logic             vFound;
      logic             pFound;
      logic [IDX_W-1:0] vSel;
      logic [IDX_W-1:0] pSel;
      logic [IDX_W-1:0] e;
      vFound = 1'b0;
      pFound = 1'b0;
      vSel   = '0;
      pSel   = '0;
      for (int k = 0; k < DEPTH; k++) begin
        e = headIdx + IDX_W'(k);
        if (vHit[e] && entMask[e][b] && qMask[b]) begin
          vFound = 1'b1;
          vSel   = e;
        end
        if (pHit[e] && entMask[e][b] && qMask[b]) begin
          pFound = 1'b1;
          pSel   = e;
        end
      end
      if (vFound) begin
        if (entDv[vSel]) fastMaskC[b] = 1'b1;
        else             fastDnrC     = 1'b1;
      end
      if (pFound) begin
        if (entDv[pSel]) begin
          fwdMaskC[b]                = 1'b1;
          fwdDataC[b*BYTE_W +: BYTE_W] = entData[pSel][b*BYTE_W +: BYTE_W];
        end else begin
          ownerUnrdy[pSel] = 1'b1;
        end
      end
    end

    dnrC    = 1'b0;
    dnrIdxC = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [IDX_W-1:0] e;
      e = headIdx + IDX_W'(k);
      if (ownerUnrdy[e]) begin
        dnrC    = 1'b1;
        dnrIdxC = e;
      end
    end

    anrC    = 1'b0;
    anrIdxC = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      logic [IDX_W-1:0] e;
      e = headIdx + IDX_W'(k);
      if (anrCand[e]) begin
        anrC    = 1'b1;
        anrIdxC = e;
      end
    end

    mismC = |(vHit ^ pHit);
  end

  assign fastFwdMask      = qValid ? fastMaskC : '0;
  assign fastDataNotReady = qValid & fastDnrC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fwdMask         <= '0;
      fwdData         <= '0;
      dataNotReady    <= 1'b0;
      dataNotReadyIdx <= '0;
      addrNotReady    <= 1'b0;
      addrNotReadyIdx <= '0;
      vpMismatch      <= 1'b0;
    end else if (qValid) begin
      fwdMask         <= fwdMaskC;
      fwdData         <= fwdDataC;
      dataNotReady    <= dnrC;
      dataNotReadyIdx <= dnrIdxC;
      addrNotReady    <= anrC;
      addrNotReadyIdx <= anrIdxC;
      vpMismatch      <= mismC;
    end else begin
      fwdMask         <= '0;
      fwdData         <= '0;
      dataNotReady    <= 1'b0;
      dataNotReadyIdx <= '0;
      addrNotReady    <= 1'b0;
      addrNotReadyIdx <= '0;
      vpMismatch      <= 1'b0;
    end
  end

  AST_FWD_WITHIN_QUERY: assert property (@(posedge clk) disable iff (!rstN)
    ((fwdMask & ~$past(qMask)) == '0)); // R6
  AST_DNR_IDX_OLDER: assert property (@(posedge clk) disable iff (!rstN)
    dataNotReady |-> ((($past(qOlderMask) >> dataNotReadyIdx) & DEPTH'(1)) != '0)); // R7
  AST_ANR_IDX_OLDER: assert property (@(posedge clk) disable iff (!rstN)
    addrNotReady |-> ((($past(qOlderMask) >> addrNotReadyIdx) & DEPTH'(1)) != '0)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !$past(qValid) |-> (fwdMask == '0 && !dataNotReady && !addrNotReady && !vpMismatch)); // R10
  AST_FAST_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !qValid |-> (fastFwdMask == '0 && !fastDataNotReady)); // R10
endmodule

// File: rtl/sqf_top.sv
module sqf_top
  import sqf_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int BYTES   = 16,
  parameter int VLINE_W = 16,
  parameter int PLINE_W = 20,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int DATA_W = BYTES * BYTE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               allocReq,
  input  logic               retireReq,
  output logic [IDX_W-1:0]   allocIdx,
  output logic               sqFull,
  output logic               sqEmpty,
  input  logic               staValid,
  input  logic [IDX_W-1:0]   staIdx,
  input  logic [VLINE_W-1:0] staVline,
  input  logic [PLINE_W-1:0] staPline,
  input  logic [BYTES-1:0]   staMask,
  input  logic               stdValid,
  input  logic [IDX_W-1:0]   stdIdx,
  input  logic [DATA_W-1:0]  stdData,
  input  logic               qValid,
  input  logic [VLINE_W-1:0] qVline,
  input  logic [PLINE_W-1:0] qPline,
  input  logic [BYTES-1:0]   qMask,
  input  logic [DEPTH-1:0]   qOlderMask,
  output logic [BYTES-1:0]   fastFwdMask,
  output logic               fastDataNotReady,
  output logic [BYTES-1:0]   fwdMask,
  output logic [DATA_W-1:0]  fwdData,
  output logic               dataNotReady,
  output logic [IDX_W-1:0]   dataNotReadyIdx,
  output logic               addrNotReady,
  output logic [IDX_W-1:0]   addrNotReadyIdx,
  output logic               vpMismatch
);
  sqStrobe_t        strobe;
  logic [IDX_W-1:0] headIdx;
  logic [IDX_W-1:0] staWrIdx;

  sqf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .allocReq (allocReq),
    .retireReq(retireReq),
    .staValid (staValid),
    .staIdx   (staIdx),
    .strobe   (strobe),
    .allocIdx (allocIdx),
    .headIdx  (headIdx),
    .staWrIdx (staWrIdx),
    .sqFull   (sqFull),
    .sqEmpty  (sqEmpty)
  );

  sqf_dpath #(
    .DEPTH  (DEPTH),
    .BYTES  (BYTES),
    .VLINE_W(VLINE_W),
    .PLINE_W(PLINE_W)
  ) u_dpath (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .allocIdx        (allocIdx),
    .headIdx         (headIdx),
    .staWrIdx        (staWrIdx),
    .staValid        (staValid),
    .staVline        (staVline),
    .staPline        (staPline),
    .staMask         (staMask),
    .stdValid        (stdValid),
    .stdIdx          (stdIdx),
    .stdData         (stdData),
    .qValid          (qValid),
    .qVline          (qVline),
    .qPline          (qPline),
    .qMask           (qMask),
    .qOlderMask      (qOlderMask),
    .fastFwdMask     (fastFwdMask),
    .fastDataNotReady(fastDataNotReady),
    .fwdMask         (fwdMask),
    .fwdData         (fwdData),
    .dataNotReady    (dataNotReady),
    .dataNotReadyIdx (dataNotReadyIdx),
    .addrNotReady    (addrNotReady),
    .addrNotReadyIdx (addrNotReadyIdx),
    .vpMismatch      (vpMismatch)
  );
endmodule

// File: tb/sqf_top_bench.sv
`timescale 1ns/1ps
module sqf_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocReq = 0, retireReq = 0, staValid = 0, stdValid = 0, qValid = 0;
  logic [2:0] staIdx = 0, stdIdx = 0;
  logic [15:0] staVline = 0, qVline = 0, staMask = 0, qMask = 0;
  logic [19:0] staPline = 0, qPline = 0;
  logic [127:0] stdData = 0;
  logic [7:0] qOlderMask = 0;
  logic [2:0] allocIdx, dataNotReadyIdx, addrNotReadyIdx;
  logic sqFull, sqEmpty, fastDataNotReady, dataNotReady, addrNotReady, vpMismatch;
  logic [15:0] fastFwdMask, fwdMask;
  logic [127:0] fwdData;

  sqf_top u_sqf_top (.*);

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  // reference model
  bit          mV [8];
  bit          mAV[8];
  bit          mDV[8];
  logic [15:0] mVl[8];
  logic [19:0] mPl[8];
  logic [15:0] mMask[8];
  logic [127:0] mData[8];
  int mHead = 0;
  int mCnt = 0;

  logic [15:0]  eFast, eFwd;
  logic [127:0] eData;
  bit eFastDnr, eDnr, eAnr, eMism;
  int eDnrIdx, eAnrIdx;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic refQuery(input logic [15:0] vl, input logic [19:0] pl, input logic [15:0] m,
                          input logic [7:0] old);
    bit owner[8];
    eFast = 0; eFwd = 0; eData = 0; eFastDnr = 0; eDnr = 0; eAnr = 0; eMism = 0;
    eDnrIdx = 0; eAnrIdx = 0;
    for (int i = 0; i < 8; i++) owner[i] = 0;
    for (int b = 0; b < 16; b++) begin
      int vs = -1;
      int ps = -1;
      for (int k = 0; k < 8; k++) begin
        int e = (mHead + k) % 8;
        if (old[e] && mV[e] && mAV[e] && mMask[e][b] && m[b]) begin
          if (mVl[e] == vl) vs = e;
          if (mPl[e] == pl) ps = e;
        end
      end
      if (vs >= 0) begin
        if (mDV[vs]) eFast[b] = 1; else eFastDnr = 1;
      end
      if (ps >= 0) begin
        if (mDV[ps]) begin eFwd[b] = 1; eData[b*8 +: 8] = mData[ps][b*8 +: 8]; end
        else owner[ps] = 1;
      end
    end
    for (int k = 0; k < 8; k++) begin
      int e = (mHead + k) % 8;
      if (owner[e]) begin eDnr = 1; eDnrIdx = e; end
    end
    for (int k = 7; k >= 0; k--) begin
      int e = (mHead + k) % 8;
      if (old[e] && mV[e] && !mAV[e]) begin eAnr = 1; eAnrIdx = e; end
    end
    for (int e = 0; e < 8; e++) begin
      if (old[e] && mV[e] && mAV[e] && ((mMask[e] & m) != 0))
        if ((mVl[e] == vl) != (mPl[e] == pl)) eMism = 1;
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic allocOp();
    if (mCnt < 8) chk(allocIdx === 3'((mHead + mCnt) % 8), "R2 allocIdx", allocIdx, (mHead + mCnt) % 8);
    allocReq = 1;
    @(negedge clk);
    allocReq = 0;
    if (mCnt < 8) begin
      int e = (mHead + mCnt) % 8;
      mV[e] = 1; mAV[e] = 0; mDV[e] = 0; mCnt++;
    end
  endtask

  task automatic retireOp();
    retireReq = 1;
    @(negedge clk);
    retireReq = 0;
    if (mCnt > 0) begin
      mV[mHead] = 0; mHead = (mHead + 1) % 8; mCnt--;
    end
  endtask

  task automatic staOp(input int e, input logic [15:0] vl, input logic [19:0] pl, input logic [15:0] m);
    staValid = 1; staIdx = 3'(e); staVline = vl; staPline = pl; staMask = m;
    @(negedge clk);
    staValid = 0;
    mAV[e] = 1; mVl[e] = vl; mPl[e] = pl; mMask[e] = m;
  endtask

  task automatic stdOp(input int e, input logic [127:0] d);
    stdValid = 1; stdIdx = 3'(e); stdData = d;
    @(negedge clk);
    stdValid = 0;
    mDV[e] = 1; mData[e] = d;
  endtask

  task automatic doQuery(input logic [15:0] vl, input logic [19:0] pl, input logic [15:0] m,
                         input logic [7:0] old);
    refQuery(vl, pl, m, old);
    qValid = 1; qVline = vl; qPline = pl; qMask = m; qOlderMask = old;
    #1;
    chk(fastFwdMask === eFast, "R5 fastFwdMask", fastFwdMask, eFast);
    chk(fastDataNotReady === eFastDnr, "R5 fastDataNotReady", fastDataNotReady, eFastDnr);
    @(negedge clk);
    qValid = 0;
    chk(fwdMask === eFwd, "R6 fwdMask", fwdMask, eFwd);
    chk(fwdData === eData, "R6 fwdData", fwdData, eData);
    chk(dataNotReady === eDnr, "R7 dataNotReady", dataNotReady, eDnr);
    if (eDnr) chk(dataNotReadyIdx === 3'(eDnrIdx), "R7 dataNotReadyIdx", dataNotReadyIdx, eDnrIdx);
    chk(addrNotReady === eAnr, "R8 addrNotReady", addrNotReady, eAnr);
    if (eAnr) chk(addrNotReadyIdx === 3'(eAnrIdx), "R8 addrNotReadyIdx", addrNotReadyIdx, eAnrIdx);
    chk(vpMismatch === eMism, "R9 vpMismatch", vpMismatch, eMism);
  endtask

  function automatic logic [15:0] pickMask();
    case ($urandom % 6)
      0: return 16'hffff;
      1: return 16'h00ff;
      2: return 16'hff00;
      3: return 16'h000f;
      4: return 16'h0f0f;
      default: return 16'($urandom) | 16'h0001;
    endcase
  endfunction

  function automatic logic [127:0] rand128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 8; i++) begin
      mV[i] = 0; mAV[i] = 0; mDV[i] = 0; mVl[i] = 0; mPl[i] = 0; mMask[i] = 0; mData[i] = 0;
    end
    idle(3);
    rstN = 1;
    idle(1);
    // R1 reset state
    chk(sqEmpty === 1'b1, "R1 sqEmpty", sqEmpty, 1);
    chk(sqFull === 1'b0, "R1 sqFull", sqFull, 0);
    chk(allocIdx === 3'd0, "R1 allocIdx", allocIdx, 0);
    chk(fwdMask === 16'h0 && !dataNotReady && !addrNotReady && !vpMismatch, "R1 stage2 outputs",
        {fwdMask, dataNotReady, addrNotReady, vpMismatch}, 0);

    // R2 fill and overfill
    for (int i = 0; i < 8; i++) allocOp();
    chk(sqFull === 1'b1, "R2 sqFull at 8", sqFull, 1);
    allocOp();
    chk(sqFull === 1'b1 && sqEmpty === 1'b0, "R2 alloc ignored when full", {sqFull, sqEmpty}, 2'b10);

    // R3 drain and retire on empty
    for (int i = 0; i < 8; i++) retireOp();
    chk(sqEmpty === 1'b1, "R3 empty after drain", sqEmpty, 1);
    retireOp();
    chk(sqEmpty === 1'b1 && sqFull === 1'b0, "R3 retire ignored when empty", {sqEmpty, sqFull}, 2'b10);

    // R4 two-cycle address visibility (entry 0 after wrap)
    allocOp();
    stdOp(0, 128'h0f0e0d0c0b0a09080706050403020100);
    staOp(0, 16'h0120, 20'h00120, 16'hffff);
    qValid = 1; qVline = 16'h0120; qPline = 20'h00120; qMask = 16'hffff; qOlderMask = 8'h01;
    @(negedge clk);
    qValid = 0;
    chk(addrNotReady === 1'b1 && addrNotReadyIdx === 3'd0, "R4 address not yet visible",
        {addrNotReady, addrNotReadyIdx}, 4'b1000);
    doQuery(16'h0120, 20'h00120, 16'hffff, 8'h01);
    chk(fwdMask === 16'hffff && !addrNotReady, "R4 address visible next cycle", fwdMask, 16'hffff);

    // R6 youngest older store per byte
    allocOp();
    stdOp(1, 128'hbbbb_bbbb_bbbb_bbbb_bbbb_bbbb_bbbb_bbbb);
    staOp(1, 16'h0120, 20'h00120, 16'h00ff);
    idle(2);
    doQuery(16'h0120, 20'h00120, 16'hffff, 8'h03);
    chk(fwdData === 128'h0f0e0d0c0b0a0908_bbbbbbbbbbbbbbbb, "R6 directed youngest merge", fwdData,
        128'h0f0e0d0c0b0a0908_bbbbbbbbbbbbbbbb);

    // R7 younger store without data shadows older data
    allocOp();
    staOp(2, 16'h0120, 20'h00120, 16'h0ff0);
    idle(2);
    doQuery(16'h0120, 20'h00120, 16'hffff, 8'h07);
    chk(dataNotReady === 1'b1 && dataNotReadyIdx === 3'd2, "R7 directed unready idx",
        {dataNotReady, dataNotReadyIdx}, 4'b1010);

    // R10 scope: older vector excludes entry 2, includes free entry 5
    doQuery(16'h0120, 20'h00120, 16'hffff, 8'h23);
    chk(dataNotReady === 1'b0, "R10 excluded entry has no effect", dataNotReady, 0);

    // R9 aliased virtual line
    allocOp();
    stdOp(3, rand128());
    staOp(3, 16'h0124, 20'h00121, 16'hffff);
    idle(2);
    doQuery(16'h0124, 20'h00120, 16'h0001, 8'h08);
    chk(vpMismatch === 1'b1, "R9 directed alias", vpMismatch, 1);

    // random phase
    for (int it = 0; it < 1500; it++) begin
      int op = $urandom % 10;
      if (op < 2) allocOp();
      else if (op < 3) retireOp();
      else if (op < 5 && mCnt > 0) begin
        int e = (mHead + ($urandom % mCnt)) % 8;
        logic [19:0] pl = 20'h00120 + 20'($urandom % 2);
        logic [15:0] vl = pl[15:0];
        if ($urandom % 8 == 0) vl = vl ^ 16'h0004;
        staOp(e, vl, pl, pickMask());
      end else if (op < 7 && mCnt > 0) begin
        stdOp((mHead + ($urandom % mCnt)) % 8, rand128());
      end else begin
        logic [19:0] pl = 20'h00120 + 20'($urandom % 2);
        logic [15:0] vl = pl[15:0];
        logic [7:0] old;
        if ($urandom % 8 == 0) vl = vl ^ 16'h0004;
        if ($urandom % 2 == 0) begin
          int n = (mCnt == 0) ? 0 : ($urandom % (mCnt + 1));
          old = 0;
          for (int k = 0; k < n; k++) old[(mHead + k) % 8] = 1;
        end else old = 8'($urandom);
        idle(2);
        doQuery(vl, pl, pickMask(), old);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule